// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block drives the row strobe, column strobe, write enable, output enable and multiplexed address of one DRAM bank whose data pins share a bus with the processor. A requester presents an address, a read/write flag and a DMA flag. It holds them until the block pulses `done`, which marks the final cycle of the access. On a read, DRAM data is valid on the shared bus in that cycle.

A timing-select input sets how long a row-miss access takes: two cycles when it is 1, three cycles when it is 0. After an access the row stays open. If the next request arrives in the very next cycle and targets the same row, it completes in a single column cycle in either timing mode. If it targets another row, the block first spends one precharge cycle with the row strobe released. If no request arrives in that cycle, the row is closed and the block goes idle.

Writes use early-write timing, so the DRAM never drives the shared bus during a write. DMA accesses are stretched by the larger of two programmed wait fields. An external wait input holds a DMA access for as long as it stays asserted.

Top module: `dram_access_seq`

## Requirements
- R1: While `rstN` is low, `rasN`, `casN`, `weN` and `oeN` are 1 and `done` is 0.
- R2: With `fastTiming` = 1, a request to a closed bank takes 2 cycles. In the first cycle `rasN` is 0 and `dramAddr` carries the row, which is `reqAddr[ADDR_W-1:COL_W]`. The second cycle is the column cycle, with `casN` = 0, `dramAddr` carrying the column (`reqAddr[COL_W-1:0]`) and `done` = 1.
- R3: With `fastTiming` = 0, a request to a closed bank takes 3 cycles. The middle cycle has `rasN` = 0 and `casN` = 1.
- R4: A request in the cycle right after `done` whose row equals the open row completes in that same cycle: `casN` = 0, the column is on `dramAddr` and `done` = 1.
- R5: A request in the cycle right after `done` whose row differs from the open row gets one cycle with `rasN` = 1, followed by a full R2/R3 access.
- R6: With no request in the cycle after `done`, `rasN` is 1 in that cycle and the row is closed, so the next request is a closed-bank access.
- R7: During a write, `weN` is 0 from the row cycle (or from the page-hit cycle) through `done`, and `oeN` stays 1. On a simple write, `weN` goes low at least one cycle before `casN` does. On a read, the `done` cycle has `oeN` = 0 and `weN` = 1.
- R8: A DMA access (`reqDma` = 1) adds max(`dmaWait`, `ioWait`) extra column cycles. A non-DMA access ignores both fields.
- R9: During a DMA access, `done` cannot occur while `extWait` = 1. A non-DMA access ignores `extWait`.
- R10: `done` is high for exactly one cycle per access, in its last cycle, and `casN` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until `done` |
| reqAddr | input | ADDR_W | Row (upper bits) and column (lower COL_W bits) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDma | input | 1 | Access belongs to a DMA transfer |
| fastTiming | input | 1 | 1 = two-cycle, 0 = three-cycle row-miss access |
| dmaWait | input | WAIT_W | DMA wait-state field |
| ioWait | input | WAIT_W | Peripheral wait-state field |
| extWait | input | 1 | External hold for DMA accesses |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | DRAM output enable, active low |
| dramAddr | output | MUX_W | Multiplexed row/column address |
| done | output | 1 | One-cycle completion strobe |

## Verification
The programmed DMA wait count and the external hold can both try to end the same column cycle. The bench provokes this by holding `extWait` for a number of cycles below, equal to, and above the point where the counter would finish. It judges the result by the cycle in which `done` appears, which must be the later of the two limits.

Page-hit detection and precharge can also fall in the cycle right after `done`. Random back-to-back requests, drawn either to the open row or to a random row, check that the row strobe stays low on a hit and is released for one cycle on a miss.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RCD  = 2'd1,
    ST_COL  = 2'd2,
    ST_OPEN = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadRow;
    logic selCol;
    logic cntLoadFull;
    logic cntLoadLess;
    logic cntDec;
  } seqStrobes_t;

endpackage

// File: rtl/dram_seq_path.sv
module dram_seq_path
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int WAIT_W = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDma,
  input  logic [WAIT_W-1:0] dmaWait,
  input  logic [WAIT_W-1:0] ioWait,
  output logic              rowHit,
  output logic              needZero,
  output logic              cntZero,
  output logic [MUX_W-1:0]  dramAddr
);

  logic [ROW_W-1:0]  reqRow;
  logic [COL_W-1:0]  reqCol;
  logic [ROW_W-1:0]  rowReg;
  logic [WAIT_W-1:0] waitNeed;
  logic [WAIT_W-1:0] waitCnt;

  assign reqRow = reqAddr[ADDR_W-1:COL_W];
  assign reqCol = reqAddr[COL_W-1:0];

  // Wait states for DMA: larger of the two programmed fields.
  always_comb begin
    if (!reqDma)                waitNeed = '0;
    else if (dmaWait > ioWait)  waitNeed = dmaWait;
    else                        waitNeed = ioWait;
  end

  assign needZero = (waitNeed == '0);
  assign cntZero  = (waitCnt == '0);
  assign rowHit   = (reqRow == rowReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rowReg <= '0;
    else if (strobes.loadRow) rowReg <= reqRow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    waitCnt <= '0;
    else if (strobes.cntLoadFull) waitCnt <= waitNeed;
    else if (strobes.cntLoadLess) waitCnt <= needZero ? '0 : waitNeed - 1'b1;
    else if (strobes.cntDec && !cntZero) waitCnt <= waitCnt - 1'b1;
  end

  // Address multiplexer, zero-extending the narrower half.
  assign dramAddr = strobes.selCol ? MUX_W'(reqCol) : MUX_W'(reqRow);

  // A counter running while no column strobe state is active must not change.
  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntLoadFull && !strobes.cntLoadLess && !strobes.cntDec) |=> $stable(waitCnt));

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqDma,
  input  logic        fastTiming,
  input  logic        extWait,
  input  logic        rowHit,
  input  logic        needZero,
  input  logic        cntZero,
  output seqStrobes_t strobes,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        oeN,
  output logic        done
);

  seqState_t state;
  seqState_t nextState;
  logic      extHold;

  assign extHold = reqDma && extWait;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    rasN      = 1'b1;
    casN      = 1'b1;
    weN       = 1'b1;
    oeN       = 1'b1;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          rasN            = 1'b0;
          weN             = !reqWrite;
          strobes.loadRow = 1'b1;
          if (fastTiming) begin
            strobes.cntLoadFull = 1'b1;
            nextState           = ST_COL;
          end else begin
            nextState = ST_RCD;
          end
        end
      end
      ST_RCD: begin
        rasN                = 1'b0;
        weN                 = !reqWrite;
        strobes.selCol      = 1'b1;
        strobes.cntLoadFull = 1'b1;
        nextState           = ST_COL;
      end
      ST_COL: begin
        rasN           = 1'b0;
        casN           = 1'b0;
        weN            = !reqWrite;
        oeN            = reqWrite;
        strobes.selCol = 1'b1;
        if (cntZero && !extHold) begin
          done      = 1'b1;
          nextState = ST_OPEN;
        end else begin
          strobes.cntDec = 1'b1;
        end
      end
      ST_OPEN: begin
        if (reqValid && rowHit) begin
          rasN           = 1'b0;
          casN           = 1'b0;
          weN            = !reqWrite;
          oeN            = reqWrite;
          strobes.selCol = 1'b1;
          if (needZero && !extHold) begin
            done = 1'b1;
          end else begin
            strobes.cntLoadLess = 1'b1;
            nextState           = ST_COL;
          end
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assert_done_cas_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!casN && !rasN));

  assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !reqValid) |-> (rasN && casN && !done));

  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && reqValid && !rowHit) |-> (rasN && casN) ##1 (state == ST_IDLE));

  assert_write_no_oe_R7: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> oeN);

  assert_early_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COL && $past(state) != ST_COL && $past(state) != ST_OPEN && !weN)
      |-> $past(!weN && casN));

  assert_ext_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqDma && extWait) |-> !done);

  assert_fast_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && fastTiming) |=> (state == ST_COL));

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int WAIT_W = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqDma,
  input  logic              fastTiming,
  input  logic [WAIT_W-1:0] dmaWait,
  input  logic [WAIT_W-1:0] ioWait,
  input  logic              extWait,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              oeN,
  output logic [MUX_W-1:0]  dramAddr,
  output logic              done
);

  seqStrobes_t strobes;
  logic        rowHit;
  logic        needZero;
  logic        cntZero;

  dram_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqDma     (reqDma),
    .fastTiming (fastTiming),
    .extWait    (extWait),
    .rowHit     (rowHit),
    .needZero   (needZero),
    .cntZero    (cntZero),
    .strobes    (strobes),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .oeN        (oeN),
    .done       (done)
  );

  dram_seq_path #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .WAIT_W (WAIT_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqDma   (reqDma),
    .dmaWait  (dmaWait),
    .ioWait   (ioWait),
    .rowHit   (rowHit),
    .needZero (needZero),
    .cntZero  (cntZero),
    .dramAddr (dramAddr)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (rasN && casN && weN && oeN && !done));

endmodule

// File: tb/dram_access_seq_test.sv
module dram_access_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 9;
  localparam int WAIT_W = 4;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic reqDma = 1'b0;
  logic fastTiming = 1'b1;
  logic [WAIT_W-1:0] dmaWait = '0;
  logic [WAIT_W-1:0] ioWait = '0;
  logic extWait = 1'b0;
  logic rasN, casN, weN, oeN, done;
  logic [MUX_W-1:0] dramAddr;

  dram_access_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .WAIT_W(WAIT_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqDma(reqDma), .fastTiming(fastTiming),
    .dmaWait(dmaWait), .ioWait(ioWait), .extWait(extWait),
    .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .dramAddr(dramAddr), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit openFlag = 1'b0;
  logic [ROW_W-1:0] openRow = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind: 0 closed bank, 1 page hit, 2 row miss on open bank
  function automatic int expLat(input int kind, input bit fast, input bit dma,
                                input int dw, input int iw, input int extK);
    int base, n, fin;
    base = (kind == 1) ? 1 : ((fast ? 2 : 3) + ((kind == 2) ? 1 : 0));
    n    = dma ? ((dw > iw) ? dw : iw) : 0;
    fin  = base - 1 + n;
    if (dma && extK > fin) fin = extK;
    return fin + 1;
  endfunction

  function automatic string latTag(input int kind, input bit fast, input bit dma, input int extK);
    if (dma && extK > 0) return "R9 ext hold latency";
    if (dma)             return "R8 dma wait latency";
    if (kind == 1)       return "R4 page hit latency";
    if (kind == 2)       return "R5 precharge+miss latency";
    return fast ? "R2 fast miss latency" : "R3 slow miss latency";
  endfunction

  task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input bit dma,
                        input bit fast, input int dw, input int iw, input int extK);
    int kind, lat, rowCyc;
    bit seen, weBad;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    row    = a[ADDR_W-1:COL_W];
    col    = a[COL_W-1:0];
    kind   = openFlag ? ((row == openRow) ? 1 : 2) : 0;
    lat    = expLat(kind, fast, dma, dw, iw, extK);
    rowCyc = (kind == 2) ? 2 : 1;
    seen   = 1'b0;
    weBad  = 1'b0;
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqDma = dma;
    fastTiming = fast; dmaWait = WAIT_W'(dw); ioWait = WAIT_W'(iw);
    for (int cyc = 1; cyc <= 80 && !seen; cyc++) begin
      extWait = (cyc <= extK);
      #1;
      if (kind == 2 && cyc == 1)
        chk(rasN == 1'b1, "R5 precharge cycle rasN", rasN, 1);
      if (kind != 1 && cyc == rowCyc)
        chk(rasN == 1'b0 && dramAddr == MUX_W'(row), "R2 row phase address", dramAddr, row);
      if (kind != 1 && !fast && cyc == rowCyc + 1)
        chk(rasN == 1'b0 && casN == 1'b1, "R3 middle cycle casN", casN, 1);
      if (wr && (kind == 1 || cyc >= rowCyc) && (weN != 1'b0 || oeN != 1'b1)) weBad = 1'b1;
      if (done) begin
        seen = 1'b1;
        chk(cyc == lat, latTag(kind, fast, dma, extK), cyc, lat);
        chk(casN == 1'b0 && dramAddr == MUX_W'(col), "R10 column in done cycle", dramAddr, col);
        if (!wr) chk(oeN == 1'b0 && weN == 1'b1, "R7 read strobes", {oeN, weN}, 1);
      end
      @(posedge clk);
      @(negedge clk);
    end
    if (!seen) chk(1'b0, "R10 done missing", 0, 1);
    if (wr) chk(!weBad, "R7 early write strobes", weBad, 0);
    extWait  = 1'b0;
    openFlag = 1'b1;
    openRow  = row;
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (i == 0) chk(rasN == 1'b1 && done == 1'b0, "R6 release after done", {rasN, done}, 2);
      else        chk(rasN == 1'b1 && casN == 1'b1, "R6 idle strobes", {rasN, casN}, 3);
      @(posedge clk);
      @(negedge clk);
    end
    openFlag = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int r, input int c);
    return {ROW_W'(r), COL_W'(c)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk(rasN && casN && weN && oeN && !done, "R1 reset outputs", {rasN, casN, weN, oeN, done}, 30);
    repeat (2) @(negedge clk);
    #1;
    chk(rasN && casN && weN && oeN && !done, "R1 reset held", {rasN, casN, weN, oeN, done}, 30);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corner cases
    access(mk(5, 17), 0, 0, 1, 0, 0, 0);      // R2 fast read miss
    access(mk(5, 18), 1, 0, 1, 0, 0, 0);      // R4 page hit write
    access(mk(9, 3),  1, 0, 0, 0, 0, 0);      // R5 miss on open row, slow write
    idle(2);                                  // R6
    access(mk(9, 4),  0, 0, 0, 0, 0, 0);      // R3 slow miss after idle
    access(mk(9, 5),  0, 1, 1, 3, 5, 0);      // R8 page hit, max picks ioWait
    access(mk(9, 6),  1, 1, 1, 7, 2, 0);      // R8 page hit, max picks dmaWait
    access(mk(9, 7),  0, 0, 1, 9, 9, 4);      // R8/R9 fields and ext ignored for non-DMA
    idle(1);
    access(mk(2, 1),  0, 1, 1, 2, 0, 3);      // R9 ext ends with counter
    access(mk(2, 2),  0, 1, 1, 2, 0, 6);      // R9 ext outlasts counter
    access(mk(2, 3),  1, 1, 0, 4, 1, 2);      // R9 ext shorter than counter
    access(mk(3, 3),  0, 1, 0, 0, 0, 5);      // R9 ext on miss, no programmed waits
    idle(1);

    // Constrained random traffic
    for (int it = 0; it < 300; it++) begin
      logic [ADDR_W-1:0] a;
      int gap;
      gap = ($urandom % 10 < 7) ? 0 : 1 + ($urandom % 2);
      if (gap > 0) idle(gap);
      if (openFlag && ($urandom % 2 == 0))
        a = {openRow, COL_W'($urandom)};
      else
        a = ADDR_W'($urandom);
      access(a, 1'($urandom), 1'($urandom), 1'($urandom),
             int'($urandom % 6), int'($urandom % 6),
             ($urandom % 10 < 3) ? int'($urandom % 8) : 0);
    end
    idle(1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule